// File: doc/BRIEF.md
# DMA Channel Address Stepper with Ring Confinement

This block produces the source (read) and destination (write) addresses for a single DMA channel. Software-side logic loads both starting addresses with one strobe. Each time the channel finishes one bus transfer, a done strobe moves every address whose increment enable is set forward by the transfer width, which is 1, 2 or 4 bytes. An address whose increment enable is clear stays at its loaded value. This serves peripheral FIFOs that sit at one fixed location.

A ring option keeps one of the two addresses inside a naturally aligned power-of-two window. When the ring option is active, only the low n address bits change and the bits above them stay frozen. This lets a circular buffer be walked without reprogramming. A select bit picks which address the ring applies to.

The same block also carries the channel's 32-bit data lane as a valid/ready stream. Data can be byte-reordered on this lane according to the transfer width. The lane adds no storage. A beat moves when `s_valid` and `m_ready` are both high. `s_ready` follows `m_ready`, and `m_valid` follows `s_valid`. A stalled producer must hold `s_data` steady, and the output then stays steady too.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, both `rd_addr` and `wr_addr` read 0.
- R2: When `load` is high at a clock edge, `rd_addr` and `wr_addr` take `init_rd_addr` and `init_wr_addr` from the next cycle. This happens even if `xfer_done` is high in the same cycle, because `load` takes priority.
- R3: When `xfer_done` is high and `load` is low, an address with its increment enable set and no ring applied advances by the step for `size_code`. Code 0 steps 1, code 1 steps 2, code 2 steps 4, and code 3 also steps 4. The sum wraps modulo 2^ADDR_W. The new value is visible on the cycle after the strobe.
- R4: An address whose increment enable (`rd_incr` or `wr_incr`) is low keeps its value across a `xfer_done` strobe.
- R5: When `ring_log2` = n > 0 and the ring applies to an address, an advance changes only its low n bits, as base − (base mod 2^n) + ((base mod 2^n + step) mod 2^n). `ring_log2` = 0 means no ring. Every n from 1 to 15 is supported, which covers windows of 2 to 32768 bytes.
- R6: When `ring_on_wr` = 0 the ring applies to the read address only. When it is 1 the ring applies to the write address only. The other address advances linearly.
- R7: In a cycle with neither `load` nor `xfer_done` high, both addresses hold their values.
- R8: `m_data` is `s_data` when `swap_en` is 0 or `size_code` is 0. With `swap_en` = 1 and `size_code` = 1, the bytes are exchanged inside each 16-bit half, so `m_data` = {s[23:16], s[31:24], s[7:0], s[15:8]}. With `size_code` of 2 or 3, all four bytes are reversed.
- R9: The stream has no storage. `m_valid` equals `s_valid` and `s_ready` equals `m_ready` in the same cycle, and `m_data` is computed from the current `s_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| load | input | 1 | Load both starting addresses |
| init_rd_addr | input | ADDR_W | Starting read address |
| init_wr_addr | input | ADDR_W | Starting write address |
| size_code | input | 2 | Transfer width: 0 byte, 1 halfword, 2/3 word |
| rd_incr | input | 1 | Read address advances per transfer |
| wr_incr | input | 1 | Write address advances per transfer |
| ring_log2 | input | RING_W | Ring window is 2^n bytes; 0 disables the ring |
| ring_on_wr | input | 1 | 0: ring on read address, 1: ring on write address |
| xfer_done | input | 1 | One transfer completed; advance addresses |
| swap_en | input | 1 | Enable byte reordering on the data lane |
| rd_addr | output | ADDR_W | Current read address |
| wr_addr | output | ADDR_W | Current write address |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted |
| s_data | input | DATA_W | Input data |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | DATA_W | Output data, possibly byte-reordered |

## Verification
The bench builds the block with its defaults: 32-bit addresses, a 4-bit ring field and a 32-bit data lane. With a 4-bit ring field, every window from 2 bytes up to 32 KiB can be reached, including a 32 KiB window crossing its top edge. With 32-bit addresses, the linear carry out of bit 31 can be observed. Randomly chosen ring sizes, widths, selects and increment enables are mixed into one run. This exercises window sizes where the window is narrower than the step, as well as ring and linear advances happening in the same cycle.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  // Bytes moved per transfer; the reserved code behaves as a word.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (xfer_size_e'(code))
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_ag_ring_mask.sv
module dma_ag_ring_mask #(
  parameter int ADDR_W = 32,
  parameter int RING_W = 4
) (
  input  logic [RING_W-1:0] ring_log2,
  output logic [ADDR_W-1:0] mask,
  output logic              wrap_on
);
  // Bit g belongs to the moving window when g < n.
  for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
    assign mask[g] = (32'(ring_log2) > g);
  end

  assign wrap_on = (ring_log2 != '0);
endmodule

// File: rtl/dma_ag_chan.sv
module dma_ag_chan #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic              adv,
  input  logic              incr,
  input  logic [2:0]        step,
  input  logic              wrap_on,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, sum, wrapped, nxt;

  always_comb begin
    sum     = addr_q + ADDR_W'(step);
    wrapped = (addr_q & ~mask) | (sum & mask);
    nxt     = addr_q;
    if (load)
      nxt = init_addr;
    else if (adv && incr)
      nxt = wrap_on ? wrapped : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= nxt;
  end

  assign addr_o = addr_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_o == $past(init_addr)));

  p_fixed_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !incr) |=> $stable(addr_o));

  p_ring_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && wrap_on) |=>
      ((addr_o & ~$past(mask)) == ($past(addr_o) & ~$past(mask))));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(addr_o));
endmodule

// File: rtl/dma_ag_swap.sv
module dma_ag_swap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        size_code,
  input  logic              swap_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);
  import dma_ag_pkg::*;

  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] half_sw, full_sw;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign half_sw[g*8 +: 8] = s_data[(g ^ 1)*8 +: 8];
    assign full_sw[g*8 +: 8] = s_data[(NB-1-g)*8 +: 8];
  end

  always_comb begin
    m_data = s_data;
    if (swap_en) begin
      case (xfer_size_e'(size_code))
        SZ_BYTE: m_data = s_data;
        SZ_HALF: m_data = half_sw;
        default: m_data = full_sw;
      endcase
    end
  end

  assign m_valid = s_valid;
  assign s_ready = m_ready;

  p_popcount_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> ($countones(m_data) == $countones(s_data)));

  p_byte_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && size_code == 2'd0) |-> (m_data == s_data));

  p_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> m_valid);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int RING_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] init_rd_addr,
  input  logic [ADDR_W-1:0] init_wr_addr,
  input  logic [1:0]        size_code,
  input  logic              rd_incr,
  input  logic              wr_incr,
  input  logic [RING_W-1:0] ring_log2,
  input  logic              ring_on_wr,
  input  logic              xfer_done,
  input  logic              swap_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);
  import dma_ag_pkg::*;

  logic [ADDR_W-1:0] mask;
  logic              wrap_on;
  logic [2:0]        step;

  assign step = size_bytes(size_code);

  dma_ag_ring_mask #(.ADDR_W(ADDR_W), .RING_W(RING_W)) u_mask (
    .ring_log2 (ring_log2),
    .mask      (mask),
    .wrap_on   (wrap_on)
  );

  dma_ag_chan #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .init_addr (init_rd_addr),
    .adv       (xfer_done),
    .incr      (rd_incr),
    .step      (step),
    .wrap_on   (wrap_on && !ring_on_wr),
    .mask      (mask),
    .addr_o    (rd_addr)
  );

  dma_ag_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .init_addr (init_wr_addr),
    .adv       (xfer_done),
    .incr      (wr_incr),
    .step      (step),
    .wrap_on   (wrap_on && ring_on_wr),
    .mask      (mask),
    .addr_o    (wr_addr)
  );

  dma_ag_swap #(.DATA_W(DATA_W)) u_swap (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_code (size_code),
    .swap_en   (swap_en),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data)
  );

  // R6: with the ring on the read side, the write address moves linearly.
  p_wr_linear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !load && wr_incr && !ring_on_wr) |=>
      (wr_addr == $past(wr_addr) + ADDR_W'($past(step))));
endmodule

// File: tb/tb_dma_addr_gen.sv
module tb_dma_addr_gen;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 0, rd_incr = 0, wr_incr = 0, ring_on_wr = 0, xfer_done = 0, swap_en = 0;
  logic [AW-1:0] init_rd_addr = '0, init_wr_addr = '0;
  logic [1:0] size_code = 0;
  logic [3:0] ring_log2 = 0;
  logic s_valid = 0, m_ready = 0;
  logic [DW-1:0] s_data = '0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic s_ready, m_valid;
  logic [DW-1:0] m_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [AW-1:0] exp_rd = '0, exp_wr = '0;

  always #2.5 clk = ~clk;

  dma_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .load(load), .init_rd_addr(init_rd_addr),
    .init_wr_addr(init_wr_addr), .size_code(size_code), .rd_incr(rd_incr),
    .wr_incr(wr_incr), .ring_log2(ring_log2), .ring_on_wr(ring_on_wr),
    .xfer_done(xfer_done), .swap_en(swap_en), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data)
  );

  function automatic logic [AW-1:0] mdl_next(input logic [AW-1:0] a, input logic en,
                                             input logic [1:0] sz, input int n, input logic ring);
    longint unsigned st, span, off, av;
    st = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    av = longint'(a);
    if (!en) return a;
    if (!ring || n == 0) return AW'(av + st);
    span = longint'(1) << n;
    off  = av % span;
    return AW'((av - off) + ((off + st) % span));
  endfunction

  function automatic logic [DW-1:0] mdl_swap(input logic [DW-1:0] d, input logic en,
                                             input logic [1:0] sz);
    if (!en || sz == 2'd0) return d;
    if (sz == 2'd1) return {d[23:16], d[31:24], d[7:0], d[15:8]};
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Inputs are set after a negedge; one posedge passes; outputs are checked at the next negedge.
  task automatic tick(input string tag_rd, input string tag_wr);
    logic [AW-1:0] nrd, nwr;
    nrd = load ? init_rd_addr :
          xfer_done ? mdl_next(exp_rd, rd_incr, size_code, int'(ring_log2), !ring_on_wr) : exp_rd;
    nwr = load ? init_wr_addr :
          xfer_done ? mdl_next(exp_wr, wr_incr, size_code, int'(ring_log2), ring_on_wr) : exp_wr;
    #1;
    chk("R9 m_valid", AW'(m_valid), AW'(s_valid));
    chk("R9 s_ready", AW'(s_ready), AW'(m_ready));
    chk("R8 m_data", m_data, mdl_swap(s_data, swap_en, size_code));
    @(negedge clk);
    exp_rd = nrd;
    exp_wr = nwr;
    chk(tag_rd, rd_addr, exp_rd);
    chk(tag_wr, wr_addr, exp_wr);
  endtask

  task automatic set_ctl(input logic ld, input logic dn, input logic [1:0] sz,
                         input logic ri, input logic wi, input logic [3:0] rn, input logic rs);
    load = ld; xfer_done = dn; size_code = sz; rd_incr = ri; wr_incr = wi;
    ring_log2 = rn; ring_on_wr = rs;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd in reset", rd_addr, '0);
    chk("R1 wr in reset", wr_addr, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd after reset", rd_addr, '0);
    chk("R1 wr after reset", wr_addr, '0);

    // R2 load
    init_rd_addr = 32'h1000_0000; init_wr_addr = 32'h2000_0000;
    set_ctl(1, 0, 0, 1, 1, 0, 0); tick("R2 rd load", "R2 wr load");
    // R3 each size code
    set_ctl(0, 1, 0, 1, 1, 0, 0); tick("R3 rd byte", "R3 wr byte");
    set_ctl(0, 1, 1, 1, 1, 0, 0); tick("R3 rd half", "R3 wr half");
    set_ctl(0, 1, 2, 1, 1, 0, 0); tick("R3 rd word", "R3 wr word");
    set_ctl(0, 1, 3, 1, 1, 0, 0); tick("R3 rd code3", "R3 wr code3");
    // R4 fixed address
    set_ctl(0, 1, 2, 0, 1, 0, 0); tick("R4 rd fixed", "R3 wr moves");
    set_ctl(0, 1, 2, 1, 0, 0, 0); tick("R3 rd moves", "R4 wr fixed");
    // R7 idle hold
    set_ctl(0, 0, 2, 1, 1, 5, 0); tick("R7 rd hold", "R7 wr hold");
    tick("R7 rd hold2", "R7 wr hold2");
    // R2 load beats done
    init_rd_addr = 32'hAAAA_0000; init_wr_addr = 32'h5555_0000;
    set_ctl(1, 1, 2, 1, 1, 0, 0); tick("R2 rd load priority", "R2 wr load priority");
    // R3 32-bit carry out
    init_rd_addr = 32'hFFFF_FFFF; init_wr_addr = 32'hFFFF_FFFE;
    set_ctl(1, 0, 0, 1, 1, 0, 0); tick("R2 rd", "R2 wr");
    set_ctl(0, 1, 1, 1, 1, 0, 0); tick("R3 rd carry", "R3 wr carry");
    // R5/R6 ring on read: 0x100000FC, 16-byte window, word -> 0x100000F0
    init_rd_addr = 32'h1000_00FC; init_wr_addr = 32'h2000_0000;
    set_ctl(1, 0, 2, 1, 1, 4, 0); tick("R2 rd", "R2 wr");
    set_ctl(0, 1, 2, 1, 1, 4, 0); tick("R5 rd ring wrap", "R6 wr linear");
    chk("R5 rd wrap value", rd_addr, 32'h1000_00F0);
    chk("R6 wr linear value", wr_addr, 32'h2000_0004);
    // R6 ring on write: 64-byte window, halfword, 0x2000003E -> 0x20000000
    init_rd_addr = 32'h1000_003E; init_wr_addr = 32'h2000_003E;
    set_ctl(1, 0, 1, 1, 1, 6, 1); tick("R2 rd", "R2 wr");
    set_ctl(0, 1, 1, 1, 1, 6, 1); tick("R6 rd linear", "R6 wr ring");
    chk("R6 wr wrap value", wr_addr, 32'h2000_0000);
    chk("R6 rd linear value", rd_addr, 32'h1000_0040);
    // R5 largest window 32 KiB
    init_rd_addr = 32'h0001_7FFC;
    set_ctl(1, 0, 2, 1, 1, 15, 0); tick("R2 rd", "R2 wr");
    set_ctl(0, 1, 2, 1, 1, 15, 0); tick("R5 rd 32K wrap", "R6 wr linear");
    chk("R5 rd 32K value", rd_addr, 32'h0001_0000);
    // R8/R9 directed stream
    s_valid = 1; m_ready = 0; s_data = 32'h1122_3344; swap_en = 1;
    set_ctl(0, 0, 1, 0, 0, 0, 0); #1;
    chk("R8 half swap", m_data, 32'h2211_4433);
    chk("R9 stall s_ready", AW'(s_ready), 0);
    chk("R9 stall m_valid", AW'(m_valid), 1);
    size_code = 2; #1; chk("R8 word swap", m_data, 32'h4433_2211);
    size_code = 0; #1; chk("R8 byte pass", m_data, 32'h1122_3344);
    size_code = 2; swap_en = 0; #1; chk("R8 swap off", m_data, 32'h1122_3344);
    @(negedge clk);

    // Random mix
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 600; i++) begin
      logic [3:0] rn;
      logic rs;
      rn = ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom_range(1, 15));
      rs = 1'($urandom);
      init_rd_addr = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFF0 + $urandom_range(0, 15) : $urandom;
      init_wr_addr = $urandom;
      s_valid = 1'($urandom); m_ready = 1'($urandom); s_data = $urandom; swap_en = 1'($urandom);
      set_ctl(($urandom_range(0, 15) == 0), 1'($urandom), 2'($urandom),
              1'($urandom), 1'($urandom), rn, rs);
      tick((rn != 0 && !rs) ? "R5 rd random" : "R3 rd random",
           (rn != 0 && rs) ? "R5 wr random" : "R3 wr random");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule